// File: doc/BRIEF.md
# Double-Buffered PWM Channel Counter

This block is one left-aligned pulse-width channel. An up-counter advances on each cycle in which the external prescale strobe `tick` is high and the channel is enabled. The counter restarts at zero once it reaches the last count of the active period. The output is driven to its asserted level while the count is below the active duty value, and to the opposite level for the rest of the period. A control field selects the channel enable, the output polarity and a 16-bit mode. In 16-bit mode two 8-bit halves form one counter, one period and one duty value.

Software reaches the channel through a simple byte-wide register port. A write strobe with an address writes one byte. A "wide" qualifier turns a write to a low-byte address into a 16-bit write. Reads use a separate combinational address. Period and duty writes land in a buffer. The active copies that the waveform uses take the buffered values only at safe points, so every period is either entirely old settings or entirely new ones. Any write to the counter clears it.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: While the enable bit (control bit 0) is 0, the counter keeps its value whatever `tick` does. While the channel is enabled, the counter advances only on cycles with `tick` high.
- R2: When the channel is enabled again, counting continues from the value the counter held. It does not restart.
- R3: A write to the counter low byte (address 1) or high byte (address 2), byte or wide, sets the whole counter to zero on that clock edge. This happens whether the channel is enabled or not, and it overrides counting.
- R4: With the 16-bit mode bit (control bit 2) set, counter, period and duty are 16 bits wide, and a write to either counter byte clears all 16 bits. With the bit clear, only the low bytes of period and duty are used and the counter wraps within 8 bits.
- R5: While enabled, the counter steps by one per tick. On a tick when the count equals the active period minus one, it returns to zero. That tick is the period end.
- R6: With the polarity bit (control bit 1) at 1, `pwm_out` is 1 while count < active duty and 0 otherwise. Polarity 0 inverts this. When the channel is disabled or the active period is zero, `pwm_out` equals the inverse of the polarity bit.
- R7: While enabled, period writes (addresses 3/4) and duty writes (addresses 5/6) change only the buffer. The buffer is copied to the active values at a period end, at a counter write, or on the edge that clears the enable bit.
- R8: While disabled, a period or duty write takes effect in the active value on the same edge.
- R9: `rd_data` returns: control at address 0 (bits 2:0), counter bytes at addresses 1/2, buffered period bytes at addresses 3/4, buffered duty bytes at addresses 5/6, and zero at address 7. Period and duty reads return the last value written, not the active one.
- R10: After reset every register is zero and `pwm_out` is 1.
- R11: A write with `reg_wide` high to address 1, 3 or 5 loads both bytes from `reg_wdata[15:0]`. A byte write takes its data from `reg_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescale strobe; one count step per high cycle |
| reg_we | input | 1 | Register write strobe |
| reg_wide | input | 1 | Marks a 16-bit write at a low-byte address |
| reg_addr | input | 3 | Write address |
| reg_wdata | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
A register write takes effect on the clock edge that samples the strobe. The counter, buffer and active values all change on that edge, and `rd_data` and `pwm_out` follow combinationally, with no further register in the path. Each counter step appears on the edge after a cycle with `tick` and enable high. The bench drives inputs just after a rising edge. It queues the expected value and compares it at the next falling edge, so every check sees the state after exactly one edge. During period, duty and enable changes the bench holds `tick` low, so the count phase is known. It then releases `tick` and checks one expected level per cycle.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_PER_LO  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_PER_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_DUTY_LO = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_DUTY_HI = 3'd6;

    localparam int CTRL_W = 3;

    typedef struct packed {
        logic wide_mode;
        logic pol;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/pwm_dbuf_shadow.sv
module pwm_dbuf_shadow #(
    parameter  int HALF_W = 8,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic              load_evt,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] lo_val,
    input  logic [HALF_W-1:0] hi_val,
    output logic [FULL_W-1:0] buf_q,
    output logic [FULL_W-1:0] act_q
);

    typedef struct packed {
        logic [FULL_W-1:0] bufv;
        logic [FULL_W-1:0] act;
    } shadow_t;

    shadow_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lo_we) st_d.bufv[HALF_W-1:0]      = lo_val;
        if (hi_we) st_d.bufv[FULL_W-1:HALF_W] = hi_val;
        if (!chan_en || load_evt) st_d.act = st_d.bufv;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign buf_q = st_q.bufv;
    assign act_q = st_q.act;

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en && !load_evt |=> $stable(act_q)); // R7

    AST_ACT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> act_q == buf_q); // R8

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter #(
    parameter  int HALF_W = 8,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              wide_mode,
    input  logic [FULL_W-1:0] per_eff,
    output logic [FULL_W-1:0] cnt_q,
    output logic              period_end
);

    typedef struct packed {
        logic [FULL_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [FULL_W-1:0] mask;
    logic [FULL_W-1:0] last;

    always_comb begin
        mask       = wide_mode ? {FULL_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        last       = (per_eff - FULL_W'(1)) & mask;
        period_end = run && (st_q.cnt == last);
        st_d       = st_q;
        if (clr)
            st_d.cnt = '0;
        else if (run)
            st_d.cnt = period_end ? '0 : ((st_q.cnt + FULL_W'(1)) & mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_q = st_q.cnt;

    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0); // R3

    AST_HOLD_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !clr |=> $stable(cnt_q)); // R1

    AST_END_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        period_end && !clr |=> cnt_q == '0); // R5

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        run && !clr && !period_end && wide_mode |=> cnt_q == $past(cnt_q) + FULL_W'(1)); // R5

endmodule

// File: rtl/pwm_dbuf_wave.sv
module pwm_dbuf_wave #(
    parameter  int HALF_W = 8,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              en,
    input  logic              pol,
    input  logic [FULL_W-1:0] cnt,
    input  logic [FULL_W-1:0] per_eff,
    input  logic [FULL_W-1:0] duty_eff,
    output logic              level
);

    logic asserted;

    always_comb begin
        asserted = en && (per_eff != '0) && (cnt < duty_eff);
        if (!en || per_eff == '0)
            level = ~pol;
        else
            level = pol ? asserted : ~asserted;
    end

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
    import pwm_dbuf_pkg::*;
#(
    parameter  int HALF_W = 8,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              reg_we,
    input  logic              reg_wide,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [FULL_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [HALF_W-1:0] rd_data,
    output logic              pwm_out
);

    localparam int NUM_SH = 2;  // 0: period, 1: duty

    typedef struct packed {
        ctrl_t ctrl;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              ctrl_we;
    logic              cnt_clr;
    logic              dis_evt;
    logic              period_end;
    logic              load_evt;
    logic [FULL_W-1:0] cnt_q;
    logic [FULL_W-1:0] sh_buf [NUM_SH];
    logic [FULL_W-1:0] sh_act [NUM_SH];
    logic [FULL_W-1:0] sh_eff [NUM_SH];

    always_comb begin
        ctrl_we = reg_we && (reg_addr == ADR_CTRL);
        cnt_clr = reg_we && ((reg_addr == ADR_CNT_LO) || (reg_addr == ADR_CNT_HI));
        st_d    = st_q;
        if (ctrl_we) st_d.ctrl = ctrl_t'(reg_wdata[CTRL_W-1:0]);
        dis_evt  = st_q.ctrl.en && !st_d.ctrl.en;
        load_evt = period_end || cnt_clr || dis_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_SH; g++) begin : g_shadow
        localparam logic [ADDR_W-1:0] LO_ADR = ADDR_W'(ADR_PER_LO + 2 * g);
        localparam logic [ADDR_W-1:0] HI_ADR = ADDR_W'(ADR_PER_LO + 2 * g + 1);

        logic              lo_we;
        logic              hi_we;
        logic [HALF_W-1:0] hi_val;

        always_comb begin
            lo_we  = reg_we && (reg_addr == LO_ADR);
            hi_we  = reg_we && ((reg_addr == HI_ADR) || ((reg_addr == LO_ADR) && reg_wide));
            hi_val = (reg_addr == HI_ADR) ? reg_wdata[HALF_W-1:0] : reg_wdata[FULL_W-1:HALF_W];
        end

        pwm_dbuf_shadow #(.HALF_W(HALF_W)) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .chan_en  (st_q.ctrl.en),
            .load_evt (load_evt),
            .lo_we    (lo_we),
            .hi_we    (hi_we),
            .lo_val   (reg_wdata[HALF_W-1:0]),
            .hi_val   (hi_val),
            .buf_q    (sh_buf[g]),
            .act_q    (sh_act[g])
        );

        assign sh_eff[g] = st_q.ctrl.wide_mode ? sh_act[g]
                                               : {{HALF_W{1'b0}}, sh_act[g][HALF_W-1:0]};
    end

    pwm_dbuf_counter #(.HALF_W(HALF_W)) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cnt_clr),
        .run        (st_q.ctrl.en && tick),
        .wide_mode  (st_q.ctrl.wide_mode),
        .per_eff    (sh_eff[0]),
        .cnt_q      (cnt_q),
        .period_end (period_end)
    );

    pwm_dbuf_wave #(.HALF_W(HALF_W)) u_wave (
        .en       (st_q.ctrl.en),
        .pol      (st_q.ctrl.pol),
        .cnt      (cnt_q),
        .per_eff  (sh_eff[0]),
        .duty_eff (sh_eff[1]),
        .level    (pwm_out)
    );

    always_comb begin
        unique case (rd_addr)
            ADR_CTRL:    rd_data = HALF_W'(st_q.ctrl);
            ADR_CNT_LO:  rd_data = cnt_q[HALF_W-1:0];
            ADR_CNT_HI:  rd_data = cnt_q[FULL_W-1:HALF_W];
            ADR_PER_LO:  rd_data = sh_buf[0][HALF_W-1:0];
            ADR_PER_HI:  rd_data = sh_buf[0][FULL_W-1:HALF_W];
            ADR_DUTY_LO: rd_data = sh_buf[1][HALF_W-1:0];
            ADR_DUTY_HI: rd_data = sh_buf[1][FULL_W-1:HALF_W];
            default:     rd_data = '0;
        endcase
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |-> pwm_out == !st_q.ctrl.pol); // R6

    AST_DISABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_evt |=> sh_act[0] == sh_buf[0] && sh_act[1] == sh_buf[1]); // R7

endmodule

// File: tb/pwm_dbuf_channel_test.sv
`timescale 1ns/1ps
module pwm_dbuf_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_wide = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        string      req;
        bit         is_out;
        logic [7:0] exp;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    pwm_dbuf_channel uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .reg_we    (reg_we),
        .reg_wide  (reg_wide),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .pwm_out   (pwm_out)
    );

    // Monitor: compares queued expectations at the falling edge
    always @(negedge clk) begin
        while (sb.size() != 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = it.is_out ? {7'b0, pwm_out} : rd_data;
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", it.req, act, it.exp, $time);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input bit wide = 1'b0);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wide = wide;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_wide = 1'b0;
    endtask

    task automatic chk_rd(input logic [2:0] a, input logic [7:0] e, input string r);
        rd_addr = a;
        sb.push_back('{r, 1'b0, e});
        @(negedge clk); #1;
    endtask

    task automatic chk_out(input logic e, input string r);
        sb.push_back('{r, 1'b1, {7'b0, e}});
        @(negedge clk); #1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk_rd(3'd0, 8'h00, "R10 ctrl");
        chk_rd(3'd1, 8'h00, "R10 cnt");
        chk_out(1'b1, "R10 out");
        chk_rd(3'd7, 8'h00, "R9 unused addr");

        // R8 direct writes while disabled, R1 hold while disabled
        tick = 1'b1;
        wr(3'd3, 16'h0004);
        wr(3'd5, 16'h0002);
        chk_rd(3'd3, 8'h04, "R9 period read");
        chk_rd(3'd1, 8'h00, "R1 disabled hold");

        // R5/R6 period 4 duty 2 polarity 1
        wr(3'd0, 16'h0003);
        chk_rd(3'd0, 8'h03, "R9 ctrl read");
        chk_out(1'b1, "R6 c1"); chk_out(1'b0, "R6 c2"); chk_out(1'b0, "R6 c3");
        chk_out(1'b1, "R5 wrap c0"); chk_out(1'b1, "R6 c1"); chk_out(1'b0, "R6 c2");
        chk_out(1'b0, "R6 c3");

        // R7 period-end load
        tick = 1'b0;
        wr(3'd3, 16'h0006);
        wr(3'd5, 16'h0005);
        chk_rd(3'd3, 8'h06, "R9 buffered period read");
        chk_out(1'b0, "R7 duty still old");
        tick = 1'b1;
        chk_out(1'b1, "R7 c0"); chk_out(1'b1, "R7 c1"); chk_out(1'b1, "R7 c2");
        chk_out(1'b1, "R7 c3"); chk_out(1'b1, "R7 c4"); chk_out(1'b0, "R7 c5");
        chk_out(1'b1, "R7 new period wrap");

        // R7 counter-write load, R3 clear
        tick = 1'b0;
        wr(3'd3, 16'h0003);
        wr(3'd5, 16'h0001);
        chk_out(1'b1, "R7 pending duty");
        wr(3'd1, 16'h00AA);
        chk_rd(3'd1, 8'h00, "R3 clear on write");
        tick = 1'b1;
        chk_out(1'b0, "R7 duty loaded by counter write");
        chk_out(1'b0, "R7 c2");
        chk_out(1'b1, "R7 period 3 wrap");

        // R7 disable load
        tick = 1'b0;
        wr(3'd5, 16'h0000);
        chk_out(1'b1, "R7 pending duty zero");
        wr(3'd0, 16'h0002);
        chk_out(1'b0, "R6 idle level pol1");
        wr(3'd0, 16'h0003);
        chk_out(1'b0, "R7 duty loaded on disable");

        // R2 resume, R1 hold
        wr(3'd0, 16'h0002);
        wr(3'd5, 16'h0002);
        wr(3'd3, 16'h0004);
        wr(3'd0, 16'h0003);
        tick = 1'b1;
        chk_rd(3'd1, 8'h00, "R5 start");
        chk_rd(3'd1, 8'h01, "R5 step");
        chk_rd(3'd1, 8'h02, "R5 step");
        tick = 1'b0;
        wr(3'd0, 16'h0002);
        tick = 1'b1;
        chk_rd(3'd1, 8'h02, "R1 hold");
        chk_rd(3'd1, 8'h02, "R1 hold");
        wr(3'd0, 16'h0003);
        chk_rd(3'd1, 8'h02, "R2 resume");
        chk_rd(3'd1, 8'h03, "R2 continue");
        chk_rd(3'd1, 8'h00, "R5 wrap");

        // R4/R11 16-bit mode
        tick = 1'b0;
        wr(3'd0, 16'h0002);
        wr(3'd0, 16'h0006);
        wr(3'd3, 16'h0104, 1'b1);
        wr(3'd5, 16'h0102, 1'b1);
        chk_rd(3'd4, 8'h01, "R11 wide period hi");
        chk_rd(3'd5, 8'h02, "R11 wide duty lo");
        wr(3'd0, 16'h0007);
        tick = 1'b1;
        repeat (257) @(posedge clk);
        #1 tick = 1'b0;
        chk_rd(3'd2, 8'h01, "R4 cnt hi");
        chk_rd(3'd1, 8'h01, "R4 cnt lo");
        chk_out(1'b1, "R6 below 16-bit duty");
        wr(3'd2, 16'h005A);
        chk_rd(3'd1, 8'h00, "R4 hi write clears lo");
        chk_rd(3'd2, 8'h00, "R4 hi write clears hi");
        tick = 1'b1;
        repeat (259) @(posedge clk);
        #1 tick = 1'b0;
        chk_rd(3'd2, 8'h01, "R4 cnt hi 259");
        chk_rd(3'd1, 8'h03, "R4 cnt lo 259");
        chk_out(1'b0, "R6 above 16-bit duty");
        tick = 1'b1;
        chk_rd(3'd2, 8'h00, "R5 16-bit wrap");
        chk_rd(3'd1, 8'h01, "R5 16-bit step");

        // R6 zero period
        tick = 1'b0;
        wr(3'd0, 16'h0006);
        wr(3'd3, 16'h0000, 1'b1);
        wr(3'd0, 16'h0007);
        chk_out(1'b0, "R6 zero period pol1");
        tick = 1'b1;
        chk_out(1'b0, "R6 zero period pol1");
        wr(3'd0, 16'h0005);
        chk_out(1'b1, "R6 zero period pol0");

        // R4 8-bit mode ignores high bytes, R6 polarity 0, R3 wide clear
        tick = 1'b0;
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'h0004, 1'b1);
        wr(3'd5, 16'h0001, 1'b1);
        wr(3'd4, 16'h0001);
        chk_rd(3'd4, 8'h01, "R9 period hi read");
        wr(3'd1, 16'h1234, 1'b1);
        chk_rd(3'd1, 8'h00, "R3 wide clear lo");
        chk_rd(3'd2, 8'h00, "R3 wide clear hi");
        wr(3'd0, 16'h0001);
        chk_out(1'b0, "R6 pol0 c0");
        tick = 1'b1;
        chk_out(1'b1, "R6 pol0 c1");
        chk_out(1'b1, "R6 pol0 c2");
        chk_out(1'b1, "R6 pol0 c3");
        chk_out(1'b0, "R4 8-bit period wrap");

        @(negedge clk); #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule